// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns a programmed burst setting and a starting column into one column address per clock for a read or write burst. It lives inside an SDRAM controller or a synthesizable SDRAM device model, between the command decoder and the array or data path. A mode-set write with a 7-bit operand programs the burst length, the beat ordering and the CAS latency. A burst-start strobe with an 8-bit column opens a burst. A burst-stop strobe ends it early.

The block can order the beats in two ways. Sequential ordering counts the low column bits upward and wraps them inside a block aligned to the burst length. Interleaved ordering XORs the low bits of the start column with the beat number. In full-page mode the column runs over all 256 columns, wraps from 255 to 0, and continues until a stop or a new start arrives. The programmed CAS latency is passed out unchanged for the read data path. Each burst captures the length and the ordering when it starts. A mode-set write made during a burst therefore applies only to bursts that start later.

Top module: `burst_col_gen`

## Requirements
- R1: After reset `beat_vld` is 0, `cas_lat` is 3, and the setting is burst length 1 with sequential ordering.
- R2: A mode-set write takes effect from the next cycle. Its operand fields are: bits [2:0] burst length (000=1, 001=2, 010=4, 011=8, 111=full page), bit 3 ordering (0 sequential, 1 interleaved), and bits [6:4] CAS latency, which appears on `cas_lat`.
- R3: A mode-set write is ignored as a whole when the length code is 100, 101 or 110, or when the CAS latency field is not 1, 2 or 3. The previous length, ordering and latency all stay in force.
- R4: A burst start at a clock edge raises `beat_vld` in the next cycle with `col_out` equal to the start column. One beat follows per clock.
- R5: Sequential ordering: beat n carries the start column with its low log2(BL) bits replaced by (start + n) mod BL. The upper bits are unchanged.
- R6: Interleaved ordering: beat n carries the start column with its low log2(BL) bits XORed with n.
- R7: For burst lengths 1, 2, 4 and 8, `beat_last` is 1 exactly on the final beat. `beat_vld` is 0 in the cycle after that beat unless a new start arrived.
- R8: A full-page sequential burst steps by one per beat, wraps from 255 to 0, and never raises `beat_last`.
- R9: A stop strobe without a start ends the burst: `beat_vld` is 0 in the next cycle, at any burst length. A start in the same cycle takes priority over the stop.
- R10: A start during a running burst abandons it. The new burst's first beat appears in the next cycle.
- R11: A running burst keeps the length and ordering in force at its start, even when a mode-set write happens during the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Mode-set write strobe |
| mode_op | input | 7 | Mode-set operand (length, ordering, CAS latency) |
| burst_go | input | 1 | Burst start strobe |
| burst_col | input | 8 | Starting column for the burst |
| burst_stop | input | 1 | Burst terminate strobe |
| col_out | output | 8 | Column address of the current beat |
| beat_vld | output | 1 | A beat is being issued in this cycle |
| beat_last | output | 1 | The current beat is the final one of a fixed-length burst |
| cas_lat | output | 2 | Programmed CAS latency (1 to 3) |

## Verification
A wrong beat counter or length mask shows at the ports within one cycle of the first affected beat. It either puts a wrong column on `col_out`, moves `beat_last` to the wrong beat, or leaves `beat_vld` high after the final beat. A corrupted setting register only becomes visible at the next `cas_lat` sample or at the next burst. For that reason every mode-set write is followed at once by a latency check and by a burst whose full column sequence is compared. Stop, restart and mid-burst mode writes are applied at a known beat, so that a fault in the priority or capture logic appears in the very next cycle.

// File: rtl/bcg_pkg.sv
// Package: shared types and operand field positions for the burst column
// generator. Assumes a 7-bit mode operand with fixed field positions.
package bcg_pkg;

    localparam int OP_W    = 7;
    localparam int LEN_LSB = 0;
    localparam int ORD_BIT = 3;
    localparam int CL_LSB  = 4;

    typedef enum logic [2:0] {
        BL_1    = 3'b000,
        BL_2    = 3'b001,
        BL_4    = 3'b010,
        BL_8    = 3'b011,
        BL_PAGE = 3'b111
    } blen_e;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } order_e;

    typedef struct packed {
        blen_e    len;
        order_e   ord;
        logic [1:0] cl;
    } burst_cfg_t;

    localparam burst_cfg_t CFG_RESET = '{len: BL_1, ord: ORD_SEQ, cl: 2'd3};

endpackage

// File: rtl/bcg_mode_reg.sv
// Mode register: holds the burst setting written by a mode-set operand.
// Assumes the operand layout from bcg_pkg; an operand with an illegal
// length code or latency is dropped as a whole.
module bcg_mode_reg
    import bcg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_wr,
    input  logic [OP_W-1:0] mode_op,
    output burst_cfg_t      cfg
);

    logic [2:0] len_f;
    logic [2:0] cl_f;
    logic       op_legal;
    burst_cfg_t cfg_q;

    // Split the operand and judge whether it is legal.
    always_comb begin
        len_f    = mode_op[LEN_LSB +: 3];
        cl_f     = mode_op[CL_LSB +: 3];
        op_legal = (len_f inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b111}) &&
                   (cl_f inside {3'd1, 3'd2, 3'd3});
    end

    // Load a legal operand; keep the old setting otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else if (mode_wr && op_legal) begin
            cfg_q.len <= blen_e'(len_f);
            cfg_q.ord <= order_e'(mode_op[ORD_BIT]);
            cfg_q.cl  <= cl_f[1:0];
        end
    end

    assign cfg = cfg_q;

    a_r3_bad_op_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && !op_legal) |=> $stable(cfg_q));

    a_r2_cl_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.cl != 2'd0);

    a_r2_op_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && op_legal) |=> (cfg_q.cl == $past(mode_op[CL_LSB +: 2])));

endmodule

// File: rtl/bcg_seq_ctrl.sv
// Burst sequencer: captures the start column and the setting at a burst
// start, counts beats, and ends on the last beat, a stop, or a restart.
// Assumes COL_W >= 3 so that an 8-beat block fits in a page.
module bcg_seq_ctrl
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             burst_go,
    input  logic [COL_W-1:0] burst_col,
    input  logic             burst_stop,
    input  burst_cfg_t       cfg,
    output logic             active,
    output logic [COL_W-1:0] start_col,
    output logic [COL_W-1:0] beat_cnt,
    output logic [COL_W-1:0] blk_mask,
    output order_e           run_ord,
    output logic             last
);

    blen_e run_len;

    // Width of the wrap block in column bits, as an all-ones mask.
    always_comb begin
        unique case (run_len)
            BL_1:    blk_mask = '0;
            BL_2:    blk_mask = COL_W'(1);
            BL_4:    blk_mask = COL_W'(3);
            BL_8:    blk_mask = COL_W'(7);
            default: blk_mask = '1;
        endcase
    end

    // The final beat of a fixed-length burst.
    always_comb last = active && (run_len != BL_PAGE) && (beat_cnt == blk_mask);

    // Sequencer state: start, stop, advance or finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            start_col <= '0;
            beat_cnt  <= '0;
            run_len   <= BL_1;
            run_ord   <= ORD_SEQ;
        end else if (burst_go) begin
            active    <= 1'b1;
            start_col <= burst_col;
            beat_cnt  <= '0;
            run_len   <= cfg.len;
            run_ord   <= cfg.ord;
        end else if (burst_stop || last) begin
            active    <= 1'b0;
        end else if (active) begin
            beat_cnt  <= beat_cnt + 1'b1;
        end
    end

    a_r4_go_opens: assert property (@(posedge clk) disable iff (!rst_n)
        burst_go |=> (active && beat_cnt == '0 && start_col == $past(burst_col)));

    a_r7_closes_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !burst_go) |=> !active);

    a_r9_stop_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_stop && !burst_go) |=> !active);

    a_r8_page_no_last: assert property (@(posedge clk) disable iff (!rst_n)
        (active && run_len == BL_PAGE) |-> !last);

    a_r11_len_held: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !$past(burst_go)) |-> $stable(run_len));

endmodule

// File: rtl/bcg_addr_map.sv
// Address mapper: forms the beat column from the start column and beat
// number. Bits outside the block mask come from the start column; bits
// inside follow the sequential or interleaved order.
module bcg_addr_map
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] start_col,
    input  logic [COL_W-1:0] beat_cnt,
    input  logic [COL_W-1:0] blk_mask,
    input  order_e           run_ord,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] low_seq;
    logic [COL_W-1:0] low_ilv;

    // Both orderings, merged with the fixed upper bits.
    always_comb begin
        low_seq = (start_col + beat_cnt) & blk_mask;
        low_ilv = (start_col ^ beat_cnt) & blk_mask;
        col     = (start_col & ~blk_mask) |
                  ((run_ord == ORD_ILV) ? low_ilv : low_seq);
    end

endmodule

// File: rtl/burst_col_gen.sv
// Top: burst column generator. Ties the mode register, the sequencer and
// the address mapper together. Assumes a single clock and a synchronous
// active-low reset; outputs are valid in the cycle after the strobes.
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [6:0]       mode_op,
    input  logic             burst_go,
    input  logic [COL_W-1:0] burst_col,
    input  logic             burst_stop,
    output logic [COL_W-1:0] col_out,
    output logic             beat_vld,
    output logic             beat_last,
    output logic [1:0]       cas_lat
);

    burst_cfg_t       cfg;
    logic [COL_W-1:0] start_col;
    logic [COL_W-1:0] beat_cnt;
    logic [COL_W-1:0] blk_mask;
    order_e           run_ord;

    bcg_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_wr (mode_wr),
        .mode_op (mode_op),
        .cfg     (cfg)
    );

    bcg_seq_ctrl #(.COL_W(COL_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .burst_go   (burst_go),
        .burst_col  (burst_col),
        .burst_stop (burst_stop),
        .cfg        (cfg),
        .active     (beat_vld),
        .start_col  (start_col),
        .beat_cnt   (beat_cnt),
        .blk_mask   (blk_mask),
        .run_ord    (run_ord),
        .last       (beat_last)
    );

    bcg_addr_map #(.COL_W(COL_W)) u_map (
        .start_col (start_col),
        .beat_cnt  (beat_cnt),
        .blk_mask  (blk_mask),
        .run_ord   (run_ord),
        .col       (col_out)
    );

    // Latency is passed straight out for the read data path.
    assign cas_lat = cfg.cl;

    a_r7_last_needs_vld: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_vld);

    a_r4_first_col: assert property (@(posedge clk) disable iff (!rst_n)
        burst_go |=> (col_out == $past(burst_col)));

    a_r8_page_step: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld && $past(beat_vld) && !$past(burst_go) && !$past(burst_stop) &&
         blk_mask == '1 && run_ord == ORD_SEQ) |-> (col_out == $past(col_out) + 1'b1));

endmodule

// File: tb/burst_col_gen_tb_top.sv
module burst_col_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 1'b0;
    logic [6:0] mode_op = '0;
    logic       burst_go = 1'b0;
    logic [7:0] burst_col = '0;
    logic       burst_stop = 1'b0;
    logic [7:0] col_out;
    logic       beat_vld;
    logic       beat_last;
    logic [1:0] cas_lat;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    burst_col_gen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_op    (mode_op),
        .burst_go   (burst_go),
        .burst_col  (burst_col),
        .burst_stop (burst_stop),
        .col_out    (col_out),
        .beat_vld   (beat_vld),
        .beat_last  (beat_last),
        .cas_lat    (cas_lat)
    );

    // Vector table: operand, start column, beats, latency, columns (beat 0 in low byte).
    localparam int NV = 7;
    localparam logic [6:0]  V_OP  [NV] = '{7'h32, 7'h3A, 7'h33, 7'h3B, 7'h21, 7'h19, 7'h30};
    localparam logic [7:0]  V_ST  [NV] = '{8'h25, 8'h25, 8'h5D, 8'h5D, 8'hFF, 8'h80, 8'h7E};
    localparam int          V_LEN [NV] = '{4, 4, 8, 8, 2, 2, 1};
    localparam int          V_CL  [NV] = '{3, 3, 3, 3, 2, 1, 3};
    localparam logic [63:0] V_COL [NV] = '{
        64'h0000_0000_2427_2625,
        64'h0000_0000_2627_2425,
        64'h5C5B_5A59_585F_5E5D,
        64'h5A5B_5859_5E5F_5C5D,
        64'h0000_0000_0000_FEFF,
        64'h0000_0000_0000_8180,
        64'h0000_0000_0000_007E
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_mode(input logic [6:0] op);
        @(negedge clk);
        mode_wr = 1'b1;
        mode_op = op;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic start(input logic [7:0] c);
        @(negedge clk);
        burst_go  = 1'b1;
        burst_col = c;
        @(negedge clk);
        burst_go  = 1'b0;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state and default burst length 1.
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 vld", beat_vld, 0);
        chk("R1 cas", cas_lat, 3);
        start(8'h44);
        chk("R1 col", col_out, 8'h44);
        chk("R1 last", beat_last, 1);
        @(negedge clk);
        chk("R1 end", beat_vld, 0);

        // Table walk: R2 latency, R5/R6 ordering, R7 last flag.
        for (int vi = 0; vi < NV; vi++) begin
            set_mode(V_OP[vi]);
            chk("R2 cas", cas_lat, V_CL[vi]);
            start(V_ST[vi]);
            for (int b = 0; b < V_LEN[vi]; b++) begin
                chk(V_OP[vi][3] ? "R6 col" : "R5 col", col_out, V_COL[vi][8*b +: 8]);
                chk("R4 vld", beat_vld, 1);
                chk("R7 last", beat_last, (b == V_LEN[vi] - 1) ? 1 : 0);
                @(negedge clk);
            end
            chk("R7 idle", beat_vld, 0);
        end

        // R3: illegal operands leave length, ordering and latency alone.
        set_mode(7'h21);
        set_mode(7'h24);
        chk("R3 cas", cas_lat, 2);
        set_mode(7'h02);
        chk("R3 cas", cas_lat, 2);
        set_mode(7'h4B);
        chk("R3 cas", cas_lat, 2);
        start(8'h10);
        chk("R3 col0", col_out, 8'h10);
        chk("R3 last0", beat_last, 0);
        @(negedge clk);
        chk("R3 col1", col_out, 8'h11);
        chk("R3 last1", beat_last, 1);
        @(negedge clk);
        chk("R3 idle", beat_vld, 0);

        // R11: mode write during a burst applies only to later bursts.
        set_mode(7'h32);
        start(8'h00);
        chk("R11 col0", col_out, 8'h00);
        mode_wr = 1'b1;
        mode_op = 7'h13;
        @(negedge clk);
        mode_wr = 1'b0;
        chk("R11 cas", cas_lat, 1);
        for (int b = 1; b < 4; b++) begin
            chk("R11 col", col_out, b);
            chk("R11 last", beat_last, (b == 3) ? 1 : 0);
            @(negedge clk);
        end
        chk("R11 idle", beat_vld, 0);
        start(8'h08);
        for (int b = 0; b < 8; b++) begin
            chk("R11 new len", beat_last, (b == 7) ? 1 : 0);
            @(negedge clk);
        end
        chk("R11 new idle", beat_vld, 0);

        // R10: restart in the middle of an 8-beat burst.
        start(8'h00);
        chk("R10 col0", col_out, 8'h00);
        @(negedge clk);
        chk("R10 col1", col_out, 8'h01);
        burst_go  = 1'b1;
        burst_col = 8'h48;
        @(negedge clk);
        burst_go  = 1'b0;
        for (int b = 0; b < 8; b++) begin
            chk("R10 col", col_out, 8'h48 + b);
            chk("R10 last", beat_last, (b == 7) ? 1 : 0);
            @(negedge clk);
        end
        chk("R10 idle", beat_vld, 0);

        // R9: stop at beat 2 of an 8-beat burst.
        start(8'h30);
        @(negedge clk);
        @(negedge clk);
        chk("R9 col2", col_out, 8'h32);
        burst_stop = 1'b1;
        @(negedge clk);
        burst_stop = 1'b0;
        chk("R9 vld", beat_vld, 0);
        chk("R9 last", beat_last, 0);

        // R9: start and stop together; the start wins.
        start(8'h30);
        burst_go   = 1'b1;
        burst_stop = 1'b1;
        burst_col  = 8'h90;
        @(negedge clk);
        burst_go   = 1'b0;
        burst_stop = 1'b0;
        chk("R9 go wins vld", beat_vld, 1);
        chk("R9 go wins col", col_out, 8'h90);
        repeat (8) @(negedge clk);
        chk("R9 go wins idle", beat_vld, 0);

        // R8: full page wraps past 255 and runs until stopped.
        set_mode(7'h37);
        start(8'hFD);
        for (int i = 0; i < 300; i++) begin
            chk("R8 col", col_out, (8'hFD + i) & 8'hFF);
            chk("R8 last", beat_last, 0);
            chk("R8 vld", beat_vld, 1);
            @(negedge clk);
        end
        burst_stop = 1'b1;
        @(negedge clk);
        burst_stop = 1'b0;
        chk("R9 page stop", beat_vld, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule